// File: doc/BRIEF.md
# Per-Block Flash Lock Gate

This block sits between a host and a flash array model. It holds one small lock register for each memory block, and it checks every array request against the lock state of the block that request targets. Reads of a read-protected block come back as all zeros. Program and block-erase requests to a write-protected block never reach the array. Instead they are accepted at once and raise a sticky error flag. All other requests pass through unchanged.

Software reaches the lock registers through a plain register port with a write strobe, a read strobe, an address and a data bus. Each register has three live bits: write protect, freeze and read protect. Once the freeze bit is set, it locks the other two bits and cannot be cleared until the next hardware reset. Array traffic uses a valid/ready handshake. A passed-through request completes when the array raises `arr_ready`. A dropped request (a protected program or erase, or a no-op) completes in the cycle it is presented. The read response is a single registered pulse, `rsp_valid`, and it has no back-pressure: the host must take it in the cycle it appears. The lock state that applies to a request is the one held in the cycle of its handshake.

Top module: `flash_lock_gate`

## Requirements
- R1: After reset, every lock register reads 8'h01: write protect set, freeze clear, read protect clear. The error flag is 0 and `rsp_valid` is 0.
- R2: Register layout: bit 0 is write protect, bit 1 is freeze and bit 2 is read protect. Bits 7..3 ignore writes and read as 0. `reg_rdata` shows the addressed register in the cycle after `reg_rd`, and holds its value otherwise.
- R3: A read (`req_cmd` = 1) completed to a block whose read protect bit is 1 gives `rsp_valid` = 1 one cycle later, with `rsp_data` = 8'h00.
- R4: A program (`req_cmd` = 2) or erase (`req_cmd` = 3) to a block whose write protect bit is 1 does not assert `arr_valid`. It sees `req_ready` = 1 in the same cycle, and `err_flag` is 1 from the next cycle on.
- R5: A program or erase to a block whose write protect bit is 0 asserts `arr_valid`, with `arr_blk` and `arr_cmd` copied from the request. Its `req_ready` equals `arr_ready`.
- R6: While a register's freeze bit is 1, writes leave its read protect and write protect bits unchanged. A write that sets freeze still updates the other two bits in that same write.
- R7: A register write cannot clear the freeze bit. Only reset returns it to 0.
- R8: `err_flag` stays 1 until `clr_err` is pulsed. If a new error and `clr_err` occur in the same cycle, the flag stays set.
- R9: A no-op request (`req_cmd` = 0) is accepted with `req_ready` = 1. It never asserts `arr_valid` and produces no response.
- R10: A read completed to a block whose read protect bit is 0 is forwarded to the array. It gives `rsp_valid` = 1 one cycle later, with `rsp_data` equal to the `arr_rdata` seen at the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Lock register write strobe |
| reg_rd | input | 1 | Lock register read strobe |
| reg_addr | input | $clog2(NUM_BLOCKS) | Lock register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after strobe |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted |
| req_blk | input | $clog2(NUM_BLOCKS) | Target block of request |
| req_cmd | input | 2 | 0 no-op, 1 read, 2 program, 3 erase |
| arr_valid | output | 1 | Forwarded request valid |
| arr_ready | input | 1 | Array accepts forwarded request |
| arr_blk | output | $clog2(NUM_BLOCKS) | Forwarded block index |
| arr_cmd | output | 2 | Forwarded command |
| arr_rdata | input | DATA_W | Array read data at read handshake |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | DATA_W | Filtered read data |
| err_flag | output | 1 | Sticky protection error |
| clr_err | input | 1 | Clears the error flag |

## Verification
The bench builds the block with NUM_BLOCKS = 8 and DATA_W = 8. That size makes a near-exhaustive sweep affordable. Every block is driven through each unfrozen combination of the two protect bits, with and without junk in the reserved bits, and under each of the four commands with `arr_ready` both high and low. Each block is then frozen with a different protect pattern, and all eight write values are replayed against it before a mid-run reset. That reset shows that the freeze bits clear and the defaults return.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  // Live lock bits; packed so rd_lock is bit 2, frz bit 1, wr_lock bit 0.
  typedef struct packed {
    logic rd_lock;
    logic frz;
    logic wr_lock;
  } lock_t;

  localparam int LOCK_W = $bits(lock_t);
  localparam lock_t LOCK_RST = '{rd_lock: 1'b0, frz: 1'b0, wr_lock: 1'b1};

  localparam logic [1:0] CMD_NOP   = 2'd0;
  localparam logic [1:0] CMD_READ  = 2'd1;
  localparam logic [1:0] CMD_PROG  = 2'd2;
  localparam logic [1:0] CMD_ERASE = 2'd3;
endpackage

// File: rtl/flash_lock_cell.sv
module flash_lock_cell
  import flash_lock_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  lock_t wr_val,
  output lock_t state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LOCK_RST;
    end else if (wr_en) begin
      // freeze applies from the next write: current value decides
      if (!state.frz) begin
        state.rd_lock <= wr_val.rd_lock;
        state.wr_lock <= wr_val.wr_lock;
      end
      state.frz <= state.frz | wr_val.frz;
    end
  end
endmodule

// File: rtl/flash_lock_bank.sv
module flash_lock_bank
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BLK_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_BLOCKS-1:0] wl_vec,
  output logic [NUM_BLOCKS-1:0] rl_vec,
  output logic [NUM_BLOCKS-1:0] ld_vec
);
  localparam int PAD_W = DATA_W - LOCK_W;

  lock_t cell_q [NUM_BLOCKS];
  lock_t wr_val;

  assign wr_val = lock_t'(reg_wdata[LOCK_W-1:0]);

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cell
    flash_lock_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr && (reg_addr == BLK_W'(g))),
      .wr_val (wr_val),
      .state  (cell_q[g])
    );
    assign wl_vec[g] = cell_q[g].wr_lock;
    assign rl_vec[g] = cell_q[g].rd_lock;
    assign ld_vec[g] = cell_q[g].frz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= {{PAD_W{1'b0}}, cell_q[reg_addr]};
    end
  end
endmodule

// File: rtl/flash_lock_path.sv
module flash_lock_path
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BLOCKS-1:0] wl_vec,
  input  logic [NUM_BLOCKS-1:0] rl_vec,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic [1:0]            req_cmd,
  output logic                  arr_valid,
  input  logic                  arr_ready,
  output logic [BLK_W-1:0]      arr_blk,
  output logic [1:0]            arr_cmd,
  input  logic [DATA_W-1:0]     arr_rdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  err_flag,
  input  logic                  clr_err
);
  logic is_mod, blocked, is_nop, dropped, fire, rd_fire;

  assign is_mod    = (req_cmd == CMD_PROG) || (req_cmd == CMD_ERASE);
  assign is_nop    = (req_cmd == CMD_NOP);
  assign blocked   = is_mod && wl_vec[req_blk];
  assign dropped   = blocked || is_nop;
  assign arr_valid = req_valid && !dropped;
  assign arr_blk   = req_blk;
  assign arr_cmd   = req_cmd;
  assign req_ready = dropped ? 1'b1 : arr_ready;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && (req_cmd == CMD_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= rl_vec[req_blk] ? '0 : arr_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err_flag <= 1'b0;
    else if (fire && blocked)  err_flag <= 1'b1;
    else if (clr_err)          err_flag <= 1'b0;
  end
endmodule

// File: rtl/flash_lock_gate.sv
module flash_lock_gate
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BLK_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [1:0]        req_cmd,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [BLK_W-1:0]  arr_blk,
  output logic [1:0]        arr_cmd,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_flag,
  input  logic              clr_err
);
  logic [NUM_BLOCKS-1:0] wl_vec, rl_vec, ld_vec;

  flash_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wl_vec    (wl_vec),
    .rl_vec    (rl_vec),
    .ld_vec    (ld_vec)
  );

  flash_lock_path #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .wl_vec    (wl_vec),
    .rl_vec    (rl_vec),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_blk   (req_blk),
    .req_cmd   (req_cmd),
    .arr_valid (arr_valid),
    .arr_ready (arr_ready),
    .arr_blk   (arr_blk),
    .arr_cmd   (arr_cmd),
    .arr_rdata (arr_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .err_flag  (err_flag),
    .clr_err   (clr_err)
  );
endmodule

// File: rtl/flash_lock_gate_chk.sv
module flash_lock_gate_chk
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int DATA_W     = 8,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [BLK_W-1:0]      req_blk,
  input logic [1:0]            req_cmd,
  input logic                  arr_valid,
  input logic                  rsp_valid,
  input logic [DATA_W-1:0]     rsp_data,
  input logic                  err_flag,
  input logic                  clr_err,
  input logic [NUM_BLOCKS-1:0] wl_vec,
  input logic [NUM_BLOCKS-1:0] rl_vec,
  input logic [NUM_BLOCKS-1:0] ld_vec
);
  p_locked_mod_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd[1] && wl_vec[req_blk]) |-> (!arr_valid && req_ready));

  p_locked_mod_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd[1] && wl_vec[req_blk]) |=> err_flag);

  p_rdlock_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd == CMD_READ && rl_vec[req_blk])
      |=> (rsp_valid && rsp_data == '0));

  p_frz_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_vec & $past(ld_vec)) == $past(ld_vec)));

  p_frz_holds_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ld_vec) & ((rl_vec ^ $past(rl_vec)) | (wl_vec ^ $past(wl_vec)))) == '0));

  p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);
endmodule

bind flash_lock_gate flash_lock_gate_chk #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_blk   (req_blk),
  .req_cmd   (req_cmd),
  .arr_valid (arr_valid),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .err_flag  (err_flag),
  .clr_err   (clr_err),
  .wl_vec    (wl_vec),
  .rl_vec    (rl_vec),
  .ld_vec    (ld_vec)
);

// File: tb/flash_lock_gate_bench.sv
`timescale 1ns/1ps
module flash_lock_gate_bench;
  localparam int NB = 8;
  localparam int DW = 8;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [BW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [BW-1:0] req_blk = '0;
  logic [1:0] req_cmd = 2'd0;
  logic arr_valid;
  logic arr_ready = 1'b0;
  logic [BW-1:0] arr_blk;
  logic [1:0] arr_cmd;
  logic [DW-1:0] arr_rdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic err_flag;
  logic clr_err = 1'b0;

  always #2.5 clk = ~clk;

  flash_lock_gate #(.NUM_BLOCKS(NB), .DATA_W(DW)) u_flash_lock_gate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk),
    .req_cmd(req_cmd), .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_blk(arr_blk), .arr_cmd(arr_cmd), .arr_rdata(arr_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_flag(err_flag),
    .clr_err(clr_err)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [2:0] mdl [NB];   // bit2 read protect, bit1 freeze, bit0 write protect
  logic err_exp = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input int b, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = BW'(b); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (!mdl[b][1]) begin
      mdl[b][2] = d[2];
      mdl[b][0] = d[0];
    end
    mdl[b][1] = mdl[b][1] | d[1];
  endtask

  task automatic rd_reg(input int b, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = BW'(b);
    @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata == {5'b0, mdl[b]}, req, reg_rdata, {5'b0, mdl[b]});
  endtask

  task automatic access(input int b, input logic [1:0] cmd, input bit rdy, input bit clr);
    logic [DW-1:0] data;
    bit pe, blocked, fwd, exp_rdy, exp_rsp;
    data = 8'h80 | DW'(b * 5 + 1);
    @(negedge clk);
    req_valid = 1'b1; req_blk = BW'(b); req_cmd = cmd;
    arr_ready = rdy; arr_rdata = data; clr_err = clr;
    #1;
    pe      = cmd[1];
    blocked = pe && mdl[b][0];
    fwd     = !blocked && (cmd != 2'd0);
    exp_rdy = fwd ? rdy : 1'b1;
    check(arr_valid == fwd, (cmd == 0) ? "R9 arr_valid" : (blocked ? "R4 arr_valid" : "R5 arr_valid"),
          arr_valid, fwd);
    check(req_ready == exp_rdy, (cmd == 0) ? "R9 req_ready" : (blocked ? "R4 req_ready" : "R5 req_ready"),
          req_ready, exp_rdy);
    if (fwd) check(arr_blk == BW'(b) && arr_cmd == cmd, "R5 arr_blk/arr_cmd",
                   {arr_blk, arr_cmd}, {BW'(b), cmd});
    if (exp_rdy && blocked) err_exp = 1'b1;
    else if (clr) err_exp = 1'b0;
    exp_rsp = exp_rdy && (cmd == 2'd1);
    @(negedge clk);
    req_valid = 1'b0; clr_err = 1'b0; arr_ready = 1'b0;
    check(rsp_valid == exp_rsp, "R3/R10 rsp_valid", rsp_valid, exp_rsp);
    if (exp_rsp) begin
      if (mdl[b][2]) check(rsp_data == 8'h00, "R3 rsp_data", rsp_data, 0);
      else check(rsp_data == data, "R10 rsp_data", rsp_data, data);
    end
    check(err_flag == err_exp, blocked ? "R4 err_flag" : "R8 err_flag", err_flag, err_exp);
  endtask

  task automatic clear_err();
    @(negedge clk);
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    err_exp = 1'b0;
    check(err_flag == 1'b0, "R8 clear", err_flag, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) mdl[i] = 3'b001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    check(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    for (int b = 0; b < NB; b++) rd_reg(b, "R1 reset value");

    // Unfrozen sweep: R2 R3 R4 R5 R9 R10
    for (int b = 0; b < NB; b++) begin
      for (int v = 0; v < 8; v++) begin
        if (v[1]) continue;
        wr_reg(b, (v[0] ^ b[0]) ? (8'hF8 | 8'(v)) : 8'(v));
        rd_reg(b, "R2 layout/reserved");
        for (int c = 0; c < 4; c++) begin
          access(b, 2'(c), 1'b1, 1'b0);
          access(b, 2'(c), 1'b0, 1'b0);
        end
        clear_err();
      end
    end

    // R8: new error and clear in the same cycle keeps the flag set
    wr_reg(0, 8'h01);
    access(0, 2'd2, 1'b1, 1'b1);
    check(err_flag == 1'b1, "R8 set wins", err_flag, 1);
    clear_err();

    // Freeze sweep: R6 R7
    for (int b = 0; b < NB; b++) begin
      wr_reg(b, {5'b0, b[0], 1'b1, b[1]});
      rd_reg(b, "R6 same-write freeze");
      for (int v = 0; v < 8; v++) begin
        wr_reg(b, 8'(v));
        rd_reg(b, "R6/R7 frozen");
        access(b, 2'd1, 1'b1, 1'b0);
        access(b, 2'd3, 1'b1, 1'b0);
      end
      clear_err();
    end

    // R7: reset clears freeze and restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) mdl[i] = 3'b001;
    err_exp = 1'b0;
    for (int b = 0; b < NB; b++) rd_reg(b, "R7 reset clears freeze");
    wr_reg(3, 8'h04);
    rd_reg(3, "R7 writable after reset");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule